// File: doc/BRIEF.md
# Device Reset-and-Select Sequencer

This block produces the addressing prologue that must come before any device command on a multi-drop single-wire bus. When started, it asks the bus engine for a bus reset and reads back whether any device answered with a presence pulse. If nothing answered, the sequence stops at once, reports an error and sends no bytes.

After a successful reset, the block sends one of three preludes as byte writes to the bus engine:
- In addressed mode with exactly one device known, it sends the single-device skip command.
- In addressed mode with any other device count, it sends the match command followed by the 64-bit device identifier.
- In resume mode, it sends only the resume command. This readdresses the device that was last matched, without resending its identifier.

Each byte write is handed over on its own and is acknowledged by the engine before the next is issued. A one-cycle done pulse closes every sequence, and the error flag is valid alongside it. Function commands and data transfer that follow selection are left to other logic.

Top module: `sel_prologue_seq`

## Requirements
- R1: A `start_i` pulse sampled while idle makes `bus_rst_req_o` high for exactly one cycle, in the cycle after the start edge. No byte write is requested before `bus_rst_done_i` returns. `bus_rst_req_o` and `wr_req_o` are never high together.
- R2: If `bus_presence_i` is 0 when `bus_rst_done_i` is sampled, the sequence requests no byte write. It ends with `done_o` and `err_o` both 1 in the following cycle. A value of 1 on `bus_presence_i` means a device answered.
- R3: In addressed mode (`resume_i` = 0) with `dev_count_i` equal to 1, exactly one byte, 0xCC, is written.
- R4: In addressed mode with `dev_count_i` not equal to 1 (including 0), nine bytes are written. The first is 0x55, followed by the identifier least significant byte first (`dev_id_i[7:0]` first, `dev_id_i[63:56]` last).
- R5: In resume mode (`resume_i` = 1), exactly one byte, 0xA5, is written, whatever the device count.
- R6: `wr_req_o` is a one-cycle pulse. After each pulse, no further write is requested until `wr_done_i` has been sampled high.
- R7: The cycle after the acknowledge of the last byte, `done_o` is high for one cycle with `err_o` = 0. `err_o` is never high without `done_o`.
- R8: Mode, count and identifier are captured when a sequence starts. A `start_i` pulse, or a change to these inputs, during a running sequence has no effect on the bytes written or on the number of resets requested.
- R9: After reset, all request, done and error outputs are low and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a sequence when idle |
| resume_i | input | 1 | 1 = resume mode, 0 = addressed mode |
| dev_count_i | input | CNT_W | Number of known devices on the bus |
| dev_id_i | input | 8*ID_BYTES | Identifier of the target device |
| bus_rst_req_o | output | 1 | One-cycle request for a bus reset |
| bus_rst_done_i | input | 1 | Bus reset complete pulse |
| bus_presence_i | input | 1 | Presence result, valid with bus_rst_done_i |
| wr_req_o | output | 1 | One-cycle byte-write request |
| wr_byte_o | output | 8 | Byte to write, valid with wr_req_o |
| wr_done_i | input | 1 | Byte-write complete pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | No presence detected, valid with done_o |

## Verification
Several rules are checked by assertions on every cycle:
- the abort-with-error that follows a missed presence;
- the clean done pulse after the last acknowledge;
- the single-cycle shape of the request and done pulses;
- the bounds of the byte index;
- the freezing of captured inputs while busy.

Other behaviour only the bench scenarios can show: the exact byte stream for each mode and device count, the least-significant-first order of the identifier, and that no write is issued while an acknowledge is still owed. The bench checks these under varied engine latencies, and with stray start pulses and input changes injected mid-sequence.

// File: rtl/selp_pkg.sv
package selp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RST   = 3'd1,
    S_RWAIT = 3'd2,
    S_WR    = 3'd3,
    S_WWAIT = 3'd4,
    S_FIN   = 3'd5
  } selp_state_t;

  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_RESUME = 8'hA5;

  // Leading command byte of a prologue.
  function automatic logic [7:0] lead_cmd(input logic resume, input logic single);
    if (resume)      lead_cmd = CMD_RESUME;
    else if (single) lead_cmd = CMD_SKIP;
    else             lead_cmd = CMD_MATCH;
  endfunction

  // Index of the final byte in a prologue carrying n_id identifier bytes.
  function automatic logic [7:0] seq_last(input logic resume, input logic single,
                                          input int unsigned n_id);
    if (resume || single) seq_last = 8'd0;
    else                  seq_last = n_id[7:0];
  endfunction

endpackage

// File: rtl/selp_byte_src.sv
module selp_byte_src
  import selp_pkg::*;
#(
  parameter int ID_BYTES = 8,
  parameter int IDX_W    = $clog2(ID_BYTES + 1)
) (
  input  logic                  resume,
  input  logic                  single,
  input  logic [8*ID_BYTES-1:0] id,
  input  logic [IDX_W-1:0]      idx,
  output logic [7:0]            byte_o,
  output logic [IDX_W-1:0]      last_idx
);
  localparam int NLANES = ID_BYTES + 1;

  logic [7:0] lane [NLANES];

  assign lane[0] = lead_cmd(resume, single);

  // Identifier bytes follow the command, least significant first.
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_lane
    assign lane[g+1] = id[8*g +: 8];
  end

  assign byte_o   = (int'(idx) < NLANES) ? lane[idx] : 8'h00;
  assign last_idx = IDX_W'(seq_last(resume, single, ID_BYTES));

endmodule

// File: rtl/selp_ctrl.sv
module selp_ctrl
  import selp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rst_done_i,
  input  logic             presence_i,
  input  logic             wr_done_i,
  input  logic [IDX_W-1:0] last_idx,
  output logic             accept_o,
  output logic             rst_req_o,
  output logic             wr_req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  selp_state_t      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;

  // Named internal events
  logic presence_miss;
  logic presence_hit;
  logic byte_ack;
  logic last_ack;

  assign presence_miss = (state_q == S_RWAIT) && rst_done_i && !presence_i;
  assign presence_hit  = (state_q == S_RWAIT) && rst_done_i &&  presence_i;
  assign byte_ack      = (state_q == S_WWAIT) && wr_done_i;
  assign last_ack      = byte_ack && (idx_q == last_idx);
  assign accept_o      = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_RST;
        idx_d   = '0;
        err_d   = 1'b0;
      end
      S_RST:   state_d = S_RWAIT;
      S_RWAIT: begin
        if (presence_miss) begin
          state_d = S_FIN;
          err_d   = 1'b1;
        end else if (presence_hit) begin
          state_d = S_WR;
        end
      end
      S_WR:    state_d = S_WWAIT;
      S_WWAIT: begin
        if (last_ack) begin
          state_d = S_FIN;
        end else if (byte_ack) begin
          state_d = S_WR;
          idx_d   = idx_q + 1'b1;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign rst_req_o = (state_q == S_RST);
  assign wr_req_o  = (state_q == S_WR);
  assign idx_o     = idx_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_FIN);
  assign err_o     = (state_q == S_FIN) && err_q;

  // R2
  abort_on_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presence_miss |=> (done_o && err_o && !wr_req_o));

  // R7
  finish_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> (done_o && !err_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && wr_req_o));

  // R1
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (rst_req_o && !wr_req_o));

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= last_idx));

endmodule

// File: rtl/sel_prologue_seq.sv
module sel_prologue_seq
  import selp_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ID_BYTES = 8,
  localparam int ID_W    = 8 * ID_BYTES,
  localparam int IDX_W   = $clog2(ID_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             resume_i,
  input  logic [CNT_W-1:0] dev_count_i,
  input  logic [ID_W-1:0]  dev_id_i,
  output logic             bus_rst_req_o,
  input  logic             bus_rst_done_i,
  input  logic             bus_presence_i,
  output logic             wr_req_o,
  output logic [7:0]       wr_byte_o,
  input  logic             wr_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic             accept;
  logic             resume_q, single_q;
  logic [ID_W-1:0]  id_q;
  logic [IDX_W-1:0] idx, last_idx;
  logic [7:0]       cur_byte;

  // Capture the request parameters on acceptance only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resume_q <= 1'b0;
      single_q <= 1'b0;
      id_q     <= '0;
    end else if (accept) begin
      resume_q <= resume_i;
      single_q <= (dev_count_i == CNT_W'(1));
      id_q     <= dev_id_i;
    end
  end

  selp_byte_src #(.ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_src (
    .resume   (resume_q),
    .single   (single_q),
    .id       (id_q),
    .idx      (idx),
    .byte_o   (cur_byte),
    .last_idx (last_idx)
  );

  selp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rst_done_i (bus_rst_done_i),
    .presence_i (bus_presence_i),
    .wr_done_i  (wr_done_i),
    .last_idx   (last_idx),
    .accept_o   (accept),
    .rst_req_o  (bus_rst_req_o),
    .wr_req_o   (wr_req_o),
    .idx_o      (idx),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign wr_byte_o = wr_req_o ? cur_byte : 8'h00;

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> ($stable(id_q) && $stable(resume_q) && $stable(single_q)));

  // R3
  first_is_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && idx == '0) |->
      (wr_byte_o == CMD_SKIP || wr_byte_o == CMD_MATCH || wr_byte_o == CMD_RESUME));

  // R5
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && resume_q) |-> (last_idx == '0));

endmodule

// File: tb/sel_prologue_seq_bench.sv
module sel_prologue_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        resume_i = 1'b0;
  logic [7:0]  dev_count_i = '0;
  logic [63:0] dev_id_i = '0;
  logic        bus_rst_req_o;
  logic        bus_rst_done_i = 1'b0;
  logic        bus_presence_i = 1'b0;
  logic        wr_req_o;
  logic [7:0]  wr_byte_o;
  logic        wr_done_i = 1'b0;
  logic        busy_o, done_o, err_o;

  always #2.5 clk = ~clk;

  sel_prologue_seq u_sel_prologue_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .dev_count_i(dev_count_i), .dev_id_i(dev_id_i),
    .bus_rst_req_o(bus_rst_req_o), .bus_rst_done_i(bus_rst_done_i),
    .bus_presence_i(bus_presence_i), .wr_req_o(wr_req_o), .wr_byte_o(wr_byte_o),
    .wr_done_i(wr_done_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected stream, restated from the requirements.
  function automatic int exp_len(input bit res, input logic [7:0] cnt);
    if (res || cnt == 8'd1) return 1;
    return 9;
  endfunction

  function automatic logic [7:0] exp_byte(input bit res, input logic [7:0] cnt,
                                          input logic [63:0] id, input int k);
    if (k == 0) return res ? 8'hA5 : ((cnt == 8'd1) ? 8'hCC : 8'h55);
    return 8'((id >> (8 * (k - 1))) & 64'hFF);
  endfunction

  // {resume, count[7:0], presence, latency[3:0], id[63:0]}
  localparam int NV = 9;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 8'd1, 1'b1, 4'd1, 64'h0123_4567_89AB_CDEF},
    {1'b0, 8'd3, 1'b1, 4'd1, 64'h8877_6655_4433_2211},
    {1'b0, 8'd0, 1'b1, 4'd3, 64'hF0E1_D2C3_B4A5_9687},
    {1'b1, 8'd5, 1'b1, 4'd2, 64'hDEAD_BEEF_CAFE_F00D},
    {1'b1, 8'd1, 1'b1, 4'd1, 64'h1111_2222_3333_4444},
    {1'b0, 8'd2, 1'b0, 4'd2, 64'hAAAA_BBBB_CCCC_DDDD},
    {1'b1, 8'd4, 1'b0, 4'd1, 64'h0000_0000_0000_0001},
    {1'b0, 8'd255, 1'b1, 4'd5, 64'h0102_0408_1020_4080},
    {1'b0, 8'd1, 1'b0, 4'd4, 64'h5555_5555_5555_5555}
  };

  task automatic run_seq(input bit res, input logic [7:0] cnt, input bit pres,
                         input int lat, input logic [63:0] id, input bit poke);
    logic [7:0] got [16];
    int nb = 0;
    int extra_rst = 0;
    int early_wr = 0;
    bit fin = 0;
    bit gerr = 0;
    int guard = 0;
    @(negedge clk);
    resume_i = res; dev_count_i = cnt; dev_id_i = id; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(bus_rst_req_o === 1'b1 && wr_req_o === 1'b0, "R1 reset request after start",
        bus_rst_req_o, 1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (bus_rst_req_o) extra_rst++;
      if (wr_req_o) early_wr++;
      if (poke && i == 0) begin
        start_i = 1'b1; resume_i = ~res; dev_count_i = cnt + 8'd1; dev_id_i = ~id;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    bus_presence_i = pres; bus_rst_done_i = 1'b1;
    while (!fin && guard < 400) begin
      @(negedge clk);
      bus_rst_done_i = 1'b0; wr_done_i = 1'b0; guard++;
      if (bus_rst_req_o) extra_rst++;
      if (wr_req_o) begin
        if (nb < 16) got[nb] = wr_byte_o;
        nb++;
        for (int j = 0; j < lat; j++) begin
          @(negedge clk);
          if (wr_req_o) early_wr++;
        end
        wr_done_i = 1'b1;
      end else if (done_o) begin
        fin = 1; gerr = err_o;
      end
    end
    chk(fin, "R7 sequence reached done", fin, 1);
    chk(early_wr == 0, "R6 no request while ack owed", early_wr, 0);
    chk(extra_rst == 0, "R8 single reset per sequence", extra_rst, 0);
    if (!pres) begin
      chk(nb == 0, "R2 no bytes after missing presence", nb, 0);
      chk(gerr == 1'b1, "R2 error with done", gerr, 1);
    end else begin
      chk(nb == exp_len(res, cnt), res ? "R5 byte count" : "R3 R4 byte count",
          nb, exp_len(res, cnt));
      chk(gerr == 1'b0, "R7 error clear on success", gerr, 0);
      for (int k = 0; k < nb && k < 16; k++)
        chk(got[k] == exp_byte(res, cnt, id, k), res ? "R5 byte" : "R3 R4 byte",
            got[k], exp_byte(res, cnt, id, k));
    end
    @(negedge clk);
    chk(done_o == 1'b0 && err_o == 1'b0 && busy_o == 1'b0, "R7 done is one pulse",
        {done_o, err_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!bus_rst_req_o && !wr_req_o && !done_o && !err_o && !busy_o, "R9 reset outputs",
        {bus_rst_req_o, wr_req_o, done_o, err_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !bus_rst_req_o, "R9 idle after reset", busy_o, 0);

    for (int v = 0; v < NV; v++)
      run_seq(VEC[v][77], VEC[v][76:69], VEC[v][68], int'(VEC[v][67:64]), VEC[v][63:0], 1'b0);

    // R8 stray start and input changes mid-sequence
    run_seq(1'b0, 8'd2, 1'b1, 3, 64'hFEDC_BA98_7654_3210, 1'b1);
    run_seq(1'b0, 8'd1, 1'b1, 2, 64'h0, 1'b1);
    run_seq(1'b1, 8'd7, 1'b1, 2, 64'h1234, 1'b1);

    // R4 count 0 with distinct bytes, long latency
    run_seq(1'b0, 8'd0, 1'b1, 6, 64'h0807_0605_0403_0201, 1'b0);

    // R9 reset in mid-sequence returns to idle
    @(negedge clk);
    start_i = 1'b1; resume_i = 1'b0; dev_count_i = 8'd3;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !bus_rst_req_o && !done_o, "R9 reset aborts sequence", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R9 stays idle", busy_o, 0);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule